// File: doc/BRIEF.md
# Frame Acquisition Lock Controller

This block decides whether a receiver has found, and is still holding, the frame alignment of an incoming symbol stream. It does not correlate anything itself. Upstream logic hands it a start-of-frame correlation magnitude with every symbol. After a header it also hands over the strongest of the 128 candidate header-code correlations, together with the index of the code that won. The controller compares these against four programmable thresholds. It reports a lock flag, the decided code index and a one-cycle frame-start strobe.

While unlocked, every symbol is a candidate frame start. A strong enough pattern match moves the controller into a tentative step, where the next code decision has to clear a stricter bar before lock is declared. Once locked, the controller stops searching. It looks up the length of the current frame from the decided code, counts symbols down, and examines only the predicted header position. That check uses a pair of looser tracking thresholds. Any miss drops it back to searching. Thresholds are unsigned fractions with seven fraction bits, so 128 means every symbol matched. Recommended values (78, 113, 46, 83) are exported from the package.

Top module: `frame_acq_lock`

## Requirements
- R1: A correlation `c` taken over `N` symbols passes a threshold `t` (8-bit unsigned, 7 fraction bits) exactly when `c*128 > t*N`. `N` is 26 for the start-of-frame pattern and 64 for the code.
- R2: While `symLocked` is low, `locked` is low from the next cycle on, and `symValid`/`codeValid` have no effect.
- R3: When unlocked, every `symValid` compares `sofCorr` with `thrSofEntry`, and a pass enters the tentative step. In the tentative step, a `codeValid` whose `codeCorr` does not pass `thrCodeEntry` returns the controller to searching with `locked` low.
- R4: In the tentative step, a `codeValid` whose `codeCorr` passes `thrCodeEntry` sets `locked` on the next cycle, and `codeIdx` then shows that cycle's `codeIdxIn`.
- R5: On each accepted code decision, the frame length `L` is taken from `frameLenIn`, which answers the lookup of `lookupIdx = codeIdxIn` in that same cycle. While locked, only the `L`-th following `symValid` is checked against `thrSofTrack`. A fail clears `locked`. The symbols before it are ignored.
- R6: After a passed tracking check, the next `codeValid` is compared with `thrCodeTrack`. A pass keeps `locked`, updates `codeIdx` and starts a new count. A fail clears `locked`.
- R7: `frameStart` is high for exactly one cycle, in the cycle after each accepted code decision, and only while `locked` is high.
- R8: A synchronous `rst` forces `locked` low, `frameStart` low and `codeIdx` to 0.
- R9: A `codeValid` while searching or while counting toward the predicted header has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| symLocked | input | 1 | Symbol timing recovery is locked |
| symValid | input | 1 | One symbol's start-of-frame correlation is present |
| sofCorr | input | 5 | Start-of-frame correlation magnitude, 0..26 |
| codeValid | input | 1 | Best code correlation for a header is present |
| codeCorr | input | 7 | Best code correlation magnitude, 0..64 |
| codeIdxIn | input | 7 | Index of the winning code |
| lookupIdx | output | 7 | Code index presented to the frame-length lookup |
| frameLenIn | input | 16 | Frame length in symbols for `lookupIdx`, at least 1 |
| thrSofEntry | input | 8 | Pattern threshold for acquiring lock |
| thrCodeEntry | input | 8 | Code threshold for acquiring lock |
| thrSofTrack | input | 8 | Pattern threshold while locked |
| thrCodeTrack | input | 8 | Code threshold while locked |
| locked | output | 1 | Frame lock status |
| codeIdx | output | 7 | Most recently accepted code index |
| frameStart | output | 1 | One-cycle strobe at each accepted header |

## Verification
The assertions rely on three things about the inputs. `frameLenIn` is never zero when a code decision is accepted. `codeValid` never arrives in the same cycle as `symValid`. Correlation magnitudes never exceed their symbol counts. The bench pulses only one of the two valid strobes per task, and it derives every frame length from the index plus three. All correlations it drives are chosen inside 0..26 and 0..64, with threshold-boundary values worked out from the `c*128 > t*N` rule.

// File: rtl/frame_acq_pkg.sv
package frame_acq_pkg;

  // recommended threshold settings, Q1.7 (128 = 1.0)
  localparam logic [7:0] THR_SOF_ENTRY_DEF  = 8'd78;
  localparam logic [7:0] THR_CODE_ENTRY_DEF = 8'd113;
  localparam logic [7:0] THR_SOF_TRACK_DEF  = 8'd46;
  localparam logic [7:0] THR_CODE_TRACK_DEF = 8'd83;

  typedef enum logic [1:0] {
    ST_SEARCH     = 2'd0,
    ST_TENTATIVE  = 2'd1,
    ST_TRACK_WAIT = 2'd2,
    ST_TRACK_CODE = 2'd3
  } acqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic acceptCode;   // load counter, capture index, raise start
    logic countEn;      // counting toward predicted header
  } ctrlStrb_t;

  // datapath -> control flags
  typedef struct packed {
    logic sofEntryHit;
    logic codeEntryHit;
    logic sofTrackHit;
    logic codeTrackHit;
    logic cntAtOne;
  } dpFlags_t;

endpackage

// File: rtl/corr_thresh.sv
module corr_thresh #(
  parameter int CORR_W   = 5,
  parameter int THR_W    = 8,
  parameter int FRAC_W   = 7,
  parameter int SYM_CNT  = 26
) (
  input  logic [CORR_W-1:0] corr,
  input  logic [THR_W-1:0]  thr,
  output logic              hit
);
  localparam int CMP_W = THR_W + $clog2(SYM_CNT + 1) + CORR_W + FRAC_W;

  logic [CMP_W-1:0] corrScaled;
  logic [CMP_W-1:0] thrScaled;

  always_comb begin
    corrScaled = CMP_W'(corr) << FRAC_W;
    thrScaled  = CMP_W'(thr) * CMP_W'(SYM_CNT);
    hit        = corrScaled > thrScaled;
  end
endmodule

// File: rtl/frame_acq_datapath.sv
module frame_acq_datapath
  import frame_acq_pkg::*;
#(
  parameter int SOF_LEN  = 26,
  parameter int CODE_LEN = 64,
  parameter int THR_W    = 8,
  parameter int FRAC_W   = 7,
  parameter int IDX_W    = 7,
  parameter int LEN_W    = 16,
  localparam int SOF_CW  = $clog2(SOF_LEN + 1),
  localparam int CODE_CW = $clog2(CODE_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               symValid,
  input  logic [SOF_CW-1:0]  sofCorr,
  input  logic [CODE_CW-1:0] codeCorr,
  input  logic [IDX_W-1:0]   codeIdxIn,
  input  logic [LEN_W-1:0]   frameLenIn,
  input  logic [THR_W-1:0]   thrSofEntry,
  input  logic [THR_W-1:0]   thrCodeEntry,
  input  logic [THR_W-1:0]   thrSofTrack,
  input  logic [THR_W-1:0]   thrCodeTrack,
  input  ctrlStrb_t          strb,
  output dpFlags_t           flags,
  output logic [IDX_W-1:0]   codeIdx,
  output logic               frameStart
);

  logic [LEN_W-1:0] symCnt;

  corr_thresh #(.CORR_W(SOF_CW), .THR_W(THR_W), .FRAC_W(FRAC_W), .SYM_CNT(SOF_LEN))
    sofEntryCmp (.corr(sofCorr), .thr(thrSofEntry), .hit(flags.sofEntryHit));
  corr_thresh #(.CORR_W(SOF_CW), .THR_W(THR_W), .FRAC_W(FRAC_W), .SYM_CNT(SOF_LEN))
    sofTrackCmp (.corr(sofCorr), .thr(thrSofTrack), .hit(flags.sofTrackHit));
  corr_thresh #(.CORR_W(CODE_CW), .THR_W(THR_W), .FRAC_W(FRAC_W), .SYM_CNT(CODE_LEN))
    codeEntryCmp (.corr(codeCorr), .thr(thrCodeEntry), .hit(flags.codeEntryHit));
  corr_thresh #(.CORR_W(CODE_CW), .THR_W(THR_W), .FRAC_W(FRAC_W), .SYM_CNT(CODE_LEN))
    codeTrackCmp (.corr(codeCorr), .thr(thrCodeTrack), .hit(flags.codeTrackHit));

  assign flags.cntAtOne = (symCnt == LEN_W'(1));

  // symbols remaining until the predicted header
  always_ff @(posedge clk) begin
    if (rst) begin
      symCnt <= '0;
    end else if (strb.acceptCode) begin
      symCnt <= frameLenIn;
    end else if (strb.countEn && symValid && (symCnt > LEN_W'(1))) begin
      symCnt <= symCnt - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codeIdx    <= '0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= strb.acceptCode;
      if (strb.acceptCode) codeIdx <= codeIdxIn;
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    strb.acceptCode |-> (frameLenIn != '0)) else $error("zero frame length"); // R5
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    strb.countEn |-> (symCnt != '0)) else $error("counter empty while tracking"); // R5
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart) else $error("frame start longer than a cycle"); // R7

endmodule

// File: rtl/frame_acq_control.sv
module frame_acq_control
  import frame_acq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      symLocked,
  input  logic      symValid,
  input  logic      codeValid,
  input  dpFlags_t  flags,
  output ctrlStrb_t strb,
  output logic      locked
);

  acqState_e state, stateNext;

  always_comb begin
    stateNext       = state;
    strb.acceptCode = 1'b0;
    strb.countEn    = 1'b0;
    if (!symLocked) begin
      stateNext = ST_SEARCH;
    end else begin
      unique case (state)
        ST_SEARCH: begin
          if (symValid && flags.sofEntryHit) stateNext = ST_TENTATIVE;
        end
        ST_TENTATIVE: begin
          if (codeValid) begin
            if (flags.codeEntryHit) begin
              stateNext       = ST_TRACK_WAIT;
              strb.acceptCode = 1'b1;
            end else begin
              stateNext = ST_SEARCH;
            end
          end
        end
        ST_TRACK_WAIT: begin
          strb.countEn = 1'b1;
          if (symValid && flags.cntAtOne)
            stateNext = flags.sofTrackHit ? ST_TRACK_CODE : ST_SEARCH;
        end
        ST_TRACK_CODE: begin
          if (codeValid) begin
            if (flags.codeTrackHit) begin
              stateNext       = ST_TRACK_WAIT;
              strb.acceptCode = 1'b1;
            end else begin
              stateNext = ST_SEARCH;
            end
          end
        end
        default: stateNext = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SEARCH;
    else     state <= stateNext;
  end

  assign locked = (state == ST_TRACK_WAIT) || (state == ST_TRACK_CODE);

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(codeValid && flags.codeEntryHit)) else $error("lock without code"); // R4
  AST_TIMING_LOSS: assert property (@(posedge clk) disable iff (rst)
    $past(!symLocked) |-> !locked) else $error("locked without symbol timing"); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(symValid && codeValid)) else $error("symbol and code strobes together"); // R5

endmodule

// File: rtl/frame_acq_lock.sv
module frame_acq_lock
  import frame_acq_pkg::*;
#(
  parameter int SOF_LEN   = 26,
  parameter int CODE_LEN  = 64,
  parameter int NUM_CODES = 128,
  parameter int THR_W     = 8,
  parameter int FRAC_W    = 7,
  parameter int LEN_W     = 16,
  localparam int SOF_CW   = $clog2(SOF_LEN + 1),
  localparam int CODE_CW  = $clog2(CODE_LEN + 1),
  localparam int IDX_W    = $clog2(NUM_CODES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               symLocked,
  input  logic               symValid,
  input  logic [SOF_CW-1:0]  sofCorr,
  input  logic               codeValid,
  input  logic [CODE_CW-1:0] codeCorr,
  input  logic [IDX_W-1:0]   codeIdxIn,
  output logic [IDX_W-1:0]   lookupIdx,
  input  logic [LEN_W-1:0]   frameLenIn,
  input  logic [THR_W-1:0]   thrSofEntry,
  input  logic [THR_W-1:0]   thrCodeEntry,
  input  logic [THR_W-1:0]   thrSofTrack,
  input  logic [THR_W-1:0]   thrCodeTrack,
  output logic               locked,
  output logic [IDX_W-1:0]   codeIdx,
  output logic               frameStart
);

  ctrlStrb_t strb;
  dpFlags_t  flags;

  assign lookupIdx = codeIdxIn;

  frame_acq_control ctrl_i (
    .clk(clk), .rst(rst), .symLocked(symLocked), .symValid(symValid),
    .codeValid(codeValid), .flags(flags), .strb(strb), .locked(locked)
  );

  frame_acq_datapath #(
    .SOF_LEN(SOF_LEN), .CODE_LEN(CODE_LEN), .THR_W(THR_W), .FRAC_W(FRAC_W),
    .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) dp_i (
    .clk(clk), .rst(rst), .symValid(symValid), .sofCorr(sofCorr),
    .codeCorr(codeCorr), .codeIdxIn(codeIdxIn), .frameLenIn(frameLenIn),
    .thrSofEntry(thrSofEntry), .thrCodeEntry(thrCodeEntry),
    .thrSofTrack(thrSofTrack), .thrCodeTrack(thrCodeTrack),
    .strb(strb), .flags(flags), .codeIdx(codeIdx), .frameStart(frameStart)
  );

  AST_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> locked) else $error("frame start while unlocked"); // R7

endmodule

// File: tb/frame_acq_lock_tb_top.sv
module frame_acq_lock_tb_top;
  import frame_acq_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       symLocked = 1'b1;
  logic       symValid = 1'b0;
  logic [4:0] sofCorr = '0;
  logic       codeValid = 1'b0;
  logic [6:0] codeCorr = '0;
  logic [6:0] codeIdxIn = '0;
  logic [6:0] lookupIdx;
  logic [15:0] frameLenIn;
  logic [7:0] thrSofEntry  = THR_SOF_ENTRY_DEF;
  logic [7:0] thrCodeEntry = THR_CODE_ENTRY_DEF;
  logic [7:0] thrSofTrack  = THR_SOF_TRACK_DEF;
  logic [7:0] thrCodeTrack = THR_CODE_TRACK_DEF;
  logic       locked;
  logic [6:0] codeIdx;
  logic       frameStart;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // frame length lookup: index + 3 symbols
  assign frameLenIn = 16'(lookupIdx) + 16'd3;

  frame_acq_lock dut_i (
    .clk(clk), .rst(rst), .symLocked(symLocked), .symValid(symValid),
    .sofCorr(sofCorr), .codeValid(codeValid), .codeCorr(codeCorr),
    .codeIdxIn(codeIdxIn), .lookupIdx(lookupIdx), .frameLenIn(frameLenIn),
    .thrSofEntry(thrSofEntry), .thrCodeEntry(thrCodeEntry),
    .thrSofTrack(thrSofTrack), .thrCodeTrack(thrCodeTrack),
    .locked(locked), .codeIdx(codeIdx), .frameStart(frameStart)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sym(int c);
    @(negedge clk);
    symValid = 1'b1;
    sofCorr = 5'(c);
    @(negedge clk);
    symValid = 1'b0;
  endtask

  task automatic code(int c, int idx);
    @(negedge clk);
    codeValid = 1'b1;
    codeCorr = 7'(c);
    codeIdxIn = 7'(idx);
    @(negedge clk);
    codeValid = 1'b0;
  endtask

  task automatic acquire(int idx);
    sym(16);
    code(57, idx);
  endtask

  task automatic testReset();
    doReset();
    chk("R8 locked after reset", int'(locked), 0);
    chk("R8 frameStart after reset", int'(frameStart), 0);
    chk("R8 codeIdx after reset", int'(codeIdx), 0);
  endtask

  task automatic testSearchMiss();
    doReset();
    code(64, 3);  // in search: ignored
    chk("R9 code while searching", int'(locked), 0);
    sym(15);      // 15*128=1920 <= 78*26=2028
    code(60, 3);
    chk("R3 pattern below entry threshold", int'(locked), 0);
    sym(16);      // 2048 > 2028 -> tentative
    code(56, 3);  // 56*128=7168 <= 113*64=7232
    chk("R3 code below entry threshold", int'(locked), 0);
    chk("R1 boundary code 56", int'(frameStart), 0);
  endtask

  task automatic testAcquire();
    doReset();
    sym(16);
    sym(0);       // ignored in tentative step
    code(57, 5);  // 7296 > 7232
    chk("R4 lock after entry", int'(locked), 1);
    chk("R4 captured index", int'(codeIdx), 5);
    chk("R7 start strobe on entry", int'(frameStart), 1);
    @(negedge clk);
    chk("R7 start strobe single cycle", int'(frameStart), 0);
  endtask

  task automatic testTrack();
    doReset();
    acquire(5);   // L = 8
    code(64, 9);  // counting: ignored
    chk("R9 code while counting", int'(codeIdx), 5);
    for (int i = 0; i < 7; i++) sym(0);
    chk("R5 early symbols ignored", int'(locked), 1);
    sym(10);      // 1280 > 46*26=1196
    chk("R5 tracking pattern pass", int'(locked), 1);
    code(42, 9);  // 5376 > 83*64=5312
    chk("R6 tracking code pass", int'(locked), 1);
    chk("R6 index updated", int'(codeIdx), 9);
    chk("R7 start strobe while tracking", int'(frameStart), 1);
    for (int i = 0; i < 11; i++) sym(26);  // L = 12
    chk("R5 counting after reload", int'(locked), 1);
    sym(9);       // 1152 <= 1196
    chk("R5 tracking pattern fail", int'(locked), 0);
  endtask

  task automatic testTrackCodeFail();
    doReset();
    acquire(0);   // L = 3
    sym(26);
    sym(26);
    sym(10);
    code(41, 2);  // 5248 <= 5312
    chk("R6 tracking code fail", int'(locked), 0);
    chk("R7 no strobe on fail", int'(frameStart), 0);
  endtask

  task automatic testTimingLoss();
    doReset();
    acquire(0);
    chk("R2 locked before loss", int'(locked), 1);
    @(negedge clk);
    symLocked = 1'b0;
    @(negedge clk);
    chk("R2 unlocked on timing loss", int'(locked), 0);
    sym(26);
    code(64, 1);
    chk("R2 inputs ignored without timing", int'(locked), 0);
    @(negedge clk);
    symLocked = 1'b1;
    code(64, 1);
    chk("R2 no leftover tentative state", int'(locked), 0);
  endtask

  task automatic testThresholds();
    doReset();
    thrSofEntry = 8'd128;  // 26*128 not > 128*26
    sym(26);
    code(64, 4);
    chk("R1 full-scale threshold never passes", int'(locked), 0);
    thrSofEntry = 8'd0;
    sym(1);
    code(57, 127);
    chk("R1 zero threshold passes on one", int'(locked), 1);
    chk("R4 top code index", int'(codeIdx), 127);
    thrSofEntry = THR_SOF_ENTRY_DEF;
  endtask

  task automatic testResetWhileLocked();
    doReset();
    acquire(7);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 reset clears lock", int'(locked), 0);
    chk("R8 reset clears index", int'(codeIdx), 0);
  endtask

  initial begin
    testReset();
    testSearchMiss();
    testAcquire();
    testTrack();
    testTrackCodeFail();
    testTimingLoss();
    testThresholds();
    testResetWhileLocked();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule